// File: doc/BRIEF.md
# Configuration Startup Sequencer

This block closes out device configuration. Once the loader has finished pushing the image into configuration memory, it raises a one-cycle start pulse and the sequencer walks through eight steps, numbered 0 to 7, at one step per configuration clock. The release events sit at steps set by parameters. One event lets the user outputs leave their held high-impedance state. One stops pulling the shared open-drain done line low. One enables writes to user flops and RAMs. A final flag marks the end of startup. That flag rises at the step after the latest release event and stays high until reset.

Three optional waits can hold the sequence at a chosen step. The first waits for the on-chip clock managers to report lock. The second waits for the I/O impedance calibration to report a match. The third is for devices wired into a chain: the block stops driving done, then waits until the sensed done line actually reads high. That line only reads high once every device on the shared net has released it, so the whole chain moves on together. While a wait is active, the step number does not change and every later event stays pending.

With the default parameters, the outputs are released at step 4, done is released at step 5, writes are enabled at step 6, and the end flag rises at step 7. The calibration wait sits at step 2, the lock wait at step 3, and the done-line wait at step 5. All three waits are enabled.

Top module: `startup_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), gts_hold_o=1, done_drive_low_o=1, write_en_o=0 and startup_end_o=0. These values hold until a start pulse is taken.
- R2: The clock edge that samples start_i=1 puts the sequencer at step 0. Each later edge with no wait active moves it up by exactly one step. Outputs depend only on the current step.
- R3: gts_hold_o falls in the edge that enters step OUT_EN_STEP (default 4). It is the first of the release events.
- R4: done_drive_low_o falls in the edge that enters step DONE_STEP (default 5). write_en_o rises in the edge that enters step WREN_STEP (default 6).
- R5: startup_end_o rises in the edge that enters the step one past the latest release event (default 7). The step count stops there, and the flag stays high until reset.
- R6: With LOCK_WAIT=1, the sequencer stays at step LOCK_STEP (default 3) while lock_i=0. It advances on the first edge at which lock_i=1.
- R7: With CAL_WAIT=1, the sequencer stays at step CAL_STEP (default 2) while cal_match_i=0. It advances on the first edge at which cal_match_i=1.
- R8: With DONE_WAIT=1, the sequencer stays at step DONE_STEP while done_sense_i=0. During that wait done_drive_low_o is already 0.
- R9: A start pulse taken while the sequence is running, or after it has finished, has no effect on the step or on any output.
- R10: Once a step's wait is satisfied and that step is passed, lock_i, cal_match_i and done_sense_i have no further effect. Every released output stays released until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle pulse: loading has completed |
| lock_i | input | 1 | Clock managers locked |
| cal_match_i | input | 1 | Impedance calibration matched |
| done_sense_i | input | 1 | Sensed level of the shared open-drain done line |
| gts_hold_o | output | 1 | 1 = user outputs held in high impedance |
| done_drive_low_o | output | 1 | 1 = pull the done line low; 0 = let it float high |
| write_en_o | output | 1 | Global write enable for user state |
| startup_end_o | output | 1 | Startup finished |

## Verification
Each result is due a fixed number of edges after the start edge: with no wait active, the output tied to step P changes exactly P edges after the edge that took start_i. When a wait is released, the held step moves on at the next edge. The bench drives inputs on falling edges. It counts the rising edges that follow the start edge and samples on a falling edge, so every expected value is the step the count predicts. Waits are checked by holding a condition low far longer than the full sequence and comparing against the outputs of the held step, then releasing it and expecting the next event exactly one edge later.

// File: rtl/startup_pkg.sv
// Shared constants and types for the startup sequencer.
// Assumes a fixed eight-step sequence; step width is derived.
package startup_pkg;
    localparam int STEP_COUNT  = 8;
    localparam int STEP_W      = $clog2(STEP_COUNT);
    localparam int EVENT_COUNT = 3;

    typedef logic [STEP_W-1:0] step_t;

    // Index of each release event in the tap array
    typedef enum int {
        EV_OUT_ENABLE   = 0,
        EV_DONE_RELEASE = 1,
        EV_WRITE_ENABLE = 2
    } event_e;

    // Largest of three step numbers
    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/startup_step_ctr.sv
// Step counter for the startup sequence.
// Idles until start_i, then counts from step 0 up to FINAL_STEP, one step
// per clock unless stall_i is high, and then holds. Start is taken once
// per reset; later pulses are ignored.
module startup_step_ctr
    import startup_pkg::*;
#(
    parameter int FINAL_STEP = 7
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  logic  stall_i,
    output step_t step_o,
    output logic  run_o
);
    localparam step_t LAST = step_t'(FINAL_STEP);

    step_t step_q;
    logic  run_q;

    // Track run state and advance the step when not stalled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            run_q  <= 1'b0;
        end else if (!run_q) begin
            if (start_i) begin
                run_q  <= 1'b1;
                step_q <= '0;
            end
        end else if (step_q != LAST && !stall_i) begin
            step_q <= step_q + 1'b1;
        end
    end

    assign step_o = step_q;
    assign run_o  = run_q;
endmodule

// File: rtl/startup_stall_gate.sv
// Combines the optional wait conditions into one stall request.
// Each wait applies only at its own step; elsewhere its input is ignored.
module startup_stall_gate
    import startup_pkg::*;
#(
    parameter bit LOCK_WAIT = 1'b1,
    parameter int LOCK_STEP = 3,
    parameter bit CAL_WAIT  = 1'b1,
    parameter int CAL_STEP  = 2,
    parameter bit DONE_WAIT = 1'b1,
    parameter int DONE_STEP = 5
) (
    input  step_t step_i,
    input  logic  lock_i,
    input  logic  cal_match_i,
    input  logic  done_sense_i,
    output logic  stall_o
);
    localparam step_t LOCK_AT = step_t'(LOCK_STEP);
    localparam step_t CAL_AT  = step_t'(CAL_STEP);
    localparam step_t DONE_AT = step_t'(DONE_STEP);

    logic lock_hold, cal_hold, done_hold;

    // Per-condition hold, each gated by its enable and step
    always_comb begin
        lock_hold = LOCK_WAIT && (step_i == LOCK_AT) && !lock_i;
        cal_hold  = CAL_WAIT  && (step_i == CAL_AT)  && !cal_match_i;
        done_hold = DONE_WAIT && (step_i == DONE_AT) && !done_sense_i;
        stall_o   = lock_hold || cal_hold || done_hold;
    end
endmodule

// File: rtl/startup_event_tap.sv
// One release event: reports fired once the running sequence has reached
// step AT_STEP. Since the step never decreases, fired stays high until
// reset.
module startup_event_tap
    import startup_pkg::*;
#(
    parameter int AT_STEP = 4
) (
    input  logic  run_i,
    input  step_t step_i,
    output logic  fired_o
);
    localparam step_t AT = step_t'(AT_STEP);

    // Event reached when running and at or past its step
    always_comb fired_o = run_i && (step_i >= AT);
endmodule

// File: rtl/startup_seq.sv
// Configuration startup sequencer, top level.
// Runs eight steps after start_i; releases outputs, done and write enable
// at parameter-chosen steps, then flags end of startup one step after the
// latest event. Assumes all inputs are synchronous to clk and that the
// event steps lie in 0..6.
module startup_seq
    import startup_pkg::*;
#(
    parameter int OUT_EN_STEP = 4,
    parameter int DONE_STEP   = 5,
    parameter int WREN_STEP   = 6,
    parameter bit LOCK_WAIT   = 1'b1,
    parameter int LOCK_STEP   = 3,
    parameter bit CAL_WAIT    = 1'b1,
    parameter int CAL_STEP    = 2,
    parameter bit DONE_WAIT   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic lock_i,
    input  logic cal_match_i,
    input  logic done_sense_i,
    output logic gts_hold_o,
    output logic done_drive_low_o,
    output logic write_en_o,
    output logic startup_end_o
);
    localparam int FINAL_STEP = max_of3(OUT_EN_STEP, DONE_STEP, WREN_STEP) + 1;
    localparam int EV_STEPS [EVENT_COUNT] = '{OUT_EN_STEP, DONE_STEP, WREN_STEP};

    if (FINAL_STEP >= STEP_COUNT) begin : g_bad_steps
        $error("startup_seq: event steps must leave room for the end step");
    end

    step_t                  step_q;
    logic                   run_q;
    logic                   stall;
    logic [EVENT_COUNT-1:0] fired;
    logic                   end_fired;

    startup_step_ctr #(
        .FINAL_STEP(FINAL_STEP)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .stall_i(stall),
        .step_o (step_q),
        .run_o  (run_q)
    );

    startup_stall_gate #(
        .LOCK_WAIT(LOCK_WAIT),
        .LOCK_STEP(LOCK_STEP),
        .CAL_WAIT (CAL_WAIT),
        .CAL_STEP (CAL_STEP),
        .DONE_WAIT(DONE_WAIT),
        .DONE_STEP(DONE_STEP)
    ) u_stall (
        .step_i      (step_q),
        .lock_i      (lock_i),
        .cal_match_i (cal_match_i),
        .done_sense_i(done_sense_i),
        .stall_o     (stall)
    );

    for (genvar e = 0; e < EVENT_COUNT; e++) begin : g_tap
        startup_event_tap #(
            .AT_STEP(EV_STEPS[e])
        ) u_tap (
            .run_i  (run_q),
            .step_i (step_q),
            .fired_o(fired[e])
        );
    end

    startup_event_tap #(
        .AT_STEP(FINAL_STEP)
    ) u_end_tap (
        .run_i  (run_q),
        .step_i (step_q),
        .fired_o(end_fired)
    );

    // Map fired events onto output polarities
    always_comb begin
        gts_hold_o       = !fired[EV_OUT_ENABLE];
        done_drive_low_o = !fired[EV_DONE_RELEASE];
        write_en_o       =  fired[EV_WRITE_ENABLE];
        startup_end_o    =  end_fired;
    end
endmodule

// File: rtl/startup_seq_chk.sv
// Assertion checker for startup_seq, attached by bind below.
// Observes ports plus the internal step and run state.
module startup_seq_chk
    import startup_pkg::*;
#(
    parameter bit LOCK_WAIT = 1'b1,
    parameter int LOCK_STEP = 3,
    parameter bit CAL_WAIT  = 1'b1,
    parameter int CAL_STEP  = 2,
    parameter bit DONE_WAIT = 1'b1,
    parameter int DONE_STEP = 5
) (
    input logic  clk,
    input logic  rst_n,
    input logic  lock_i,
    input logic  cal_match_i,
    input logic  done_sense_i,
    input logic  gts_hold_o,
    input logic  done_drive_low_o,
    input logic  write_en_o,
    input logic  startup_end_o,
    input step_t step,
    input logic  run
);
    localparam step_t LOCK_AT = step_t'(LOCK_STEP);
    localparam step_t CAL_AT  = step_t'(CAL_STEP);
    localparam step_t DONE_AT = step_t'(DONE_STEP);

    assert_idle_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (gts_hold_o && done_drive_low_o && !write_en_o && !startup_end_o));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (step == $past(step) || step == step_t'($past(step) + 1'b1)));

    assert_end_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        startup_end_o |=> startup_end_o);

    assert_end_after_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        startup_end_o |-> (!gts_hold_o && !done_drive_low_o && write_en_o));

    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (LOCK_WAIT && run && step == LOCK_AT && !lock_i) |=> $stable(step));

    assert_cal_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (CAL_WAIT && run && step == CAL_AT && !cal_match_i) |=> $stable(step));

    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (DONE_WAIT && run && step == DONE_AT && !done_sense_i) |=> $stable(step));

    assert_done_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step == DONE_AT) |-> !done_drive_low_o);

    assert_gts_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !gts_hold_o |=> !gts_hold_o);

    assert_we_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        write_en_o |=> write_en_o);
endmodule

bind startup_seq startup_seq_chk #(
    .LOCK_WAIT(LOCK_WAIT),
    .LOCK_STEP(LOCK_STEP),
    .CAL_WAIT (CAL_WAIT),
    .CAL_STEP (CAL_STEP),
    .DONE_WAIT(DONE_WAIT),
    .DONE_STEP(DONE_STEP)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .lock_i          (lock_i),
    .cal_match_i     (cal_match_i),
    .done_sense_i    (done_sense_i),
    .gts_hold_o      (gts_hold_o),
    .done_drive_low_o(done_drive_low_o),
    .write_en_o      (write_en_o),
    .startup_end_o   (startup_end_o),
    .step            (step_q),
    .run             (run_q)
);

// File: tb/startup_seq_tb.sv
`timescale 1ns/1ps
// Bench for startup_seq with default parameters.
// Outputs are compared as {gts_hold, done_drive_low, write_en, startup_end}.
module startup_seq_tb;
    logic clk = 1'b0;
    logic rst_n, start_i, lock_i, cal_match_i, done_sense_i;
    logic gts_hold_o, done_drive_low_o, write_en_o, startup_end_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    startup_seq u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .lock_i          (lock_i),
        .cal_match_i     (cal_match_i),
        .done_sense_i    (done_sense_i),
        .gts_hold_o      (gts_hold_o),
        .done_drive_low_o(done_drive_low_o),
        .write_en_o      (write_en_o),
        .startup_end_o   (startup_end_o)
    );

    // Vector: {lock, cal, done_sense, edges after start[4:0], expected[3:0]}
    localparam int NVEC = 11;
    localparam logic [11:0] VEC [NVEC] = '{
        {3'b111, 5'd0,  4'b1100},  // R2 step 0
        {3'b111, 5'd3,  4'b1100},  // R2 step 3
        {3'b111, 5'd4,  4'b0100},  // R3 outputs released
        {3'b111, 5'd5,  4'b0000},  // R4 done released
        {3'b111, 5'd6,  4'b0010},  // R4 write enable
        {3'b111, 5'd7,  4'b0011},  // R5 end flag
        {3'b111, 5'd20, 4'b0011},  // R5 holds at end
        {3'b011, 5'd20, 4'b1100},  // R6 held at lock step
        {3'b101, 5'd20, 4'b1100},  // R7 held at cal step
        {3'b110, 5'd20, 4'b0000},  // R8 held at done step, drive released
        {3'b000, 5'd20, 4'b1100}   // R7 cal step comes first
    };

    function automatic logic [3:0] outs();
        return {gts_hold_o, done_drive_low_o, write_en_o, startup_end_o};
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, outs(), exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Pulse start across one rising edge; returns at the falling edge after it
    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        lock_i = 1'b1; cal_match_i = 1'b1; done_sense_i = 1'b1;
        rst_n = 1'b0; start_i = 1'b0;
        @(negedge clk);
        do_reset();
        check("R1 reset state", 4'b1100);
        wait_edges(10);
        check("R1 idle without start", 4'b1100);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            {lock_i, cal_match_i, done_sense_i} = VEC[i][11:9];
            pulse_start();
            wait_edges(int'(VEC[i][8:4]));
            check($sformatf("R2-table vector %0d", i), VEC[i][3:0]);
        end

        // R6: lock released late -> outputs release one edge later
        do_reset();
        lock_i = 1'b0; cal_match_i = 1'b1; done_sense_i = 1'b1;
        pulse_start();
        wait_edges(15);
        check("R6 held while unlocked", 4'b1100);
        lock_i = 1'b1;
        wait_edges(1);
        check("R6 advance on lock", 4'b0100);

        // R10: dropping lock after its step has no effect
        lock_i = 1'b0;
        wait_edges(3);
        check("R10 lock ignored later", 4'b0011);

        // R7: cal released late
        do_reset();
        lock_i = 1'b1; cal_match_i = 1'b0;
        pulse_start();
        wait_edges(12);
        cal_match_i = 1'b1;
        wait_edges(2);
        check("R7 advance on match", 4'b0100);

        // R8: done sense released late, then end one edge after write enable
        do_reset();
        done_sense_i = 1'b0;
        pulse_start();
        wait_edges(14);
        check("R8 waiting on done line", 4'b0000);
        done_sense_i = 1'b1;
        wait_edges(1);
        check("R8 write enable after done high", 4'b0010);
        wait_edges(1);
        check("R5 end after write enable", 4'b0011);

        // R9: start during the run does not restart
        do_reset();
        pulse_start();
        wait_edges(2);
        pulse_start();
        wait_edges(1);
        check("R9 start mid-run ignored", 4'b0100);
        wait_edges(5);
        pulse_start();
        wait_edges(2);
        check("R9 start after finish ignored", 4'b0011);

        // R1: reset mid-sequence
        do_reset();
        pulse_start();
        wait_edges(5);
        rst_n = 1'b0;
        wait_edges(1);
        rst_n = 1'b1;
        check("R1 reset mid-run", 4'b1100);

        report();
    end
endmodule